// File: doc/BRIEF.md
# Next Program Counter Selector

This block owns the program counter of a small in-order fetch stage. On every rising clock edge it loads the next fetch address. A decoded transfer mode chooses how that address is formed. The address can be the following instruction, an absolute address field, a PC-relative target, the contents of a register, or a target two instructions ahead when a skip condition holds. A separate condition selector gates the absolute, relative and register-indirect transfers. When the condition is false, the block falls back to sequential flow.

Instructions are a fixed four bytes long. The relative offset counts instructions, so it is sign-extended and scaled before it is added to the address of the following instruction. A call raises the link request, and the block stores that same following-instruction address as the return address. A later return is an indirect transfer through the register that holds that value. A stall input freezes the whole block.

Top module: `npc_sel`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` loads `RESET_VEC` (default 0x0000_1000) and `link` loads zero. Reset takes priority over stall.
- R2: Mode 0 (sequential) and the unused codes 5, 6 and 7 load `pc + 4`, whatever `cond_sel`, `imm`, `rs_a`, `rs_b` and `flag` hold.
- R3: Mode 1 (absolute), when its condition holds, loads the full `imm` value unchanged into `pc`.
- R4: Mode 2 (PC-relative), when its condition holds, loads `pc + 4 + (sext(imm[9:0]) << 2)`. Here bit 9 is the sign bit, so targets both before and after the current instruction can be reached.
- R5: Mode 3 (register indirect), when its condition holds, loads `rs_a` into `pc`.
- R6: Mode 4 (skip-if-equal) loads `pc + 8` when `rs_a == rs_b` and `pc + 4` otherwise. `cond_sel` and `flag` play no part in this mode.
- R7: For modes 1 to 3 the condition is chosen by `cond_sel`: 0 always true, 1 `rs_a == rs_b`, 2 `rs_a != 0`, 3 `flag == 1`. When the condition is false, `pc` loads `pc + 4`.
- R8: While `stall` is high and `rst` is low, `pc` and `link` keep their values.
- R9: When `link_req` is high and `stall` is low, `link` loads `pc + 4` of that cycle. Otherwise `link` holds its value.
- R10: `taken` is combinational. It is 1 in the same cycle exactly when modes 1 to 3 have a true condition, or mode 4 has `rs_a == rs_b`. It is 0 for all other mode codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze PC and link |
| mode | input | 3 | Transfer mode code |
| cond_sel | input | 2 | Condition kind for modes 1 to 3 |
| imm | input | 32 | Absolute address, or relative offset in its low 10 bits |
| rs_a | input | 32 | First register operand |
| rs_b | input | 32 | Second register operand |
| flag | input | 1 | Previously set status flag |
| link_req | input | 1 | Capture the return address |
| pc | output | 32 | Current program counter |
| link | output | 32 | Stored return address |
| taken | output | 1 | Current transfer is taken |

## Verification
The assertions take for granted that every input is a known value at each rising edge. They also assume `rst` is held for at least one edge before the first checked transfer, so that `$past` relations start from a defined PC. The stimulus drives every input away from the clock edge and releases reset only after two edges. It forces `rs_a == rs_b` and `rs_a == 0` often enough that each condition kind and the skip path are seen both true and false. Stalls, link requests, unused mode codes and one reset in the middle of the run are mixed into the random traffic.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        XM_SEQ  = 3'd0,
        XM_ABS  = 3'd1,
        XM_REL  = 3'd2,
        XM_IND  = 3'd3,
        XM_SKIP = 3'd4
    } xfer_mode_e;

    typedef enum logic [1:0] {
        CK_ALWAYS = 2'd0,
        CK_EQ     = 2'd1,
        CK_NZ     = 2'd2,
        CK_FLAG   = 2'd3
    } cond_kind_e;

    typedef struct packed {
        xfer_mode_e kind;
        logic       go;
    } xfer_dec_t;

    // Map the raw code onto a mode; codes with no meaning fall back to sequential.
    function automatic xfer_mode_e decode_mode(input logic [2:0] code);
        xfer_mode_e m;
        case (code)
            3'd1:    m = XM_ABS;
            3'd2:    m = XM_REL;
            3'd3:    m = XM_IND;
            3'd4:    m = XM_SKIP;
            default: m = XM_SEQ;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   mode_code,
    input  logic [1:0]   cond_code,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         flag_in,
    output xfer_dec_t    dec
);
    logic       ops_eq;
    logic       opa_nz;
    logic       cond_ok;
    xfer_mode_e kind;
    cond_kind_e ck;

    assign ops_eq = (opa == opb);
    assign opa_nz = |opa;
    assign kind   = decode_mode(mode_code);
    assign ck     = cond_kind_e'(cond_code);

    always_comb begin
        case (ck)
            CK_EQ:   cond_ok = ops_eq;
            CK_NZ:   cond_ok = opa_nz;
            CK_FLAG: cond_ok = flag_in;
            default: cond_ok = 1'b1;
        endcase
    end

    always_comb begin
        dec.kind = kind;
        case (kind)
            XM_ABS, XM_REL, XM_IND: dec.go = cond_ok;
            XM_SKIP:                dec.go = ops_eq;
            default:                dec.go = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int OFF_W       = 10,
    parameter int INSTR_BYTES = 4
) (
    input  logic [PC_W-1:0] pc_cur,
    input  xfer_dec_t       dec,
    input  logic [PC_W-1:0] imm_in,
    input  logic [PC_W-1:0] reg_in,
    output logic [PC_W-1:0] pc_next,
    output logic [PC_W-1:0] ret_addr
);
    localparam int SH = $clog2(INSTR_BYTES);
    localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] skip_addr;
    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] rel_addr;

    assign seq_addr  = pc_cur + STEP;
    assign skip_addr = seq_addr + STEP;
    assign off_ext   = {{(PC_W-OFF_W){imm_in[OFF_W-1]}}, imm_in[OFF_W-1:0]};
    assign rel_addr  = seq_addr + (off_ext << SH);
    assign ret_addr  = seq_addr;

    always_comb begin
        pc_next = seq_addr;
        if (dec.go) begin
            case (dec.kind)
                XM_ABS:  pc_next = imm_in;
                XM_REL:  pc_next = rel_addr;
                XM_IND:  pc_next = reg_in;
                XM_SKIP: pc_next = skip_addr;
                default: pc_next = seq_addr;
            endcase
        end
    end
endmodule

// File: rtl/npc_sel.sv
module npc_sel
    import npc_pkg::*;
#(
    parameter int              PC_W        = 32,
    parameter int              OFF_W       = 10,
    parameter int              INSTR_BYTES = 4,
    parameter logic [PC_W-1:0] RESET_VEC   = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic [2:0]      mode,
    input  logic [1:0]      cond_sel,
    input  logic [PC_W-1:0] imm,
    input  logic [PC_W-1:0] rs_a,
    input  logic [PC_W-1:0] rs_b,
    input  logic            flag,
    input  logic            link_req,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] link,
    output logic            taken
);
    xfer_dec_t       dec;
    logic [PC_W-1:0] pc_next;
    logic [PC_W-1:0] ret_addr;

    npc_cond #(.W(PC_W)) u_cond (
        .mode_code (mode),
        .cond_code (cond_sel),
        .opa       (rs_a),
        .opb       (rs_b),
        .flag_in   (flag),
        .dec       (dec)
    );

    npc_target #(
        .PC_W        (PC_W),
        .OFF_W       (OFF_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_target (
        .pc_cur   (pc),
        .dec      (dec),
        .imm_in   (imm),
        .reg_in   (rs_a),
        .pc_next  (pc_next),
        .ret_addr (ret_addr)
    );

    assign taken = dec.go;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= RESET_VEC;
            link <= '0;
        end else if (!stall) begin
            pc <= pc_next;
            if (link_req) begin
                link <= ret_addr;
            end
        end
    end
endmodule

// File: rtl/npc_sel_chk.sv
module npc_sel_chk #(
    parameter int              PC_W      = 32,
    parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_1000
) (
    input logic            clk,
    input logic            rst,
    input logic            stall,
    input logic [2:0]      mode,
    input logic [PC_W-1:0] imm,
    input logic [PC_W-1:0] rs_a,
    input logic [PC_W-1:0] rs_b,
    input logic            link_req,
    input logic [PC_W-1:0] pc,
    input logic [PC_W-1:0] link,
    input logic            taken
);
    localparam logic [PC_W-1:0] ONE  = PC_W'(4);
    localparam logic [PC_W-1:0] TWO  = PC_W'(8);

    logic seen_edge = 1'b0;
    logic rst_d     = 1'b0;
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        rst_d     <= rst;
    end

    always_ff @(negedge clk) begin
        if (seen_edge && rst_d) begin
            AST_RESET_VALUE: assert (pc == RESET_VEC && link == '0); // R1
        end
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!stall && (mode == 3'd0 || mode > 3'd4)) |=> pc == $past(pc) + ONE); // R2

    AST_ABS_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!stall && mode == 3'd1 && taken) |=> pc == $past(imm)); // R3

    AST_IND_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!stall && mode == 3'd3 && taken) |=> pc == $past(rs_a)); // R5

    AST_SKIP_STEP: assert property (@(posedge clk) disable iff (rst)
        (!stall && mode == 3'd4) |=>
            pc == $past(pc) + ($past(rs_a == rs_b) ? TWO : ONE)); // R6

    AST_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        (!stall && !taken) |=> pc == $past(pc) + ONE); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(pc) && $stable(link))); // R8

    AST_LINK_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!stall && link_req) |=> link == $past(pc) + ONE); // R9

    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !link_req |=> $stable(link)); // R9

    AST_SEQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 || mode > 3'd4) |-> !taken); // R10
endmodule

bind npc_sel npc_sel_chk #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stall    (stall),
    .mode     (mode),
    .imm      (imm),
    .rs_a     (rs_a),
    .rs_b     (rs_b),
    .link_req (link_req),
    .pc       (pc),
    .link     (link),
    .taken    (taken)
);

// File: tb/npc_sel_tb.sv
`timescale 1ns/100ps
module npc_sel_tb;
    localparam logic [31:0] RV = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [1:0]  cond_sel = 2'd0;
    logic [31:0] imm = '0;
    logic [31:0] rs_a = '0;
    logic [31:0] rs_b = '0;
    logic        flag = 1'b0;
    logic        link_req = 1'b0;
    logic [31:0] pc;
    logic [31:0] link;
    logic        taken;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_pc = RV;
    logic [31:0] m_link = '0;

    always #2.5 clk = ~clk;

    npc_sel u_dut (
        .clk(clk), .rst(rst), .stall(stall), .mode(mode), .cond_sel(cond_sel),
        .imm(imm), .rs_a(rs_a), .rs_b(rs_b), .flag(flag), .link_req(link_req),
        .pc(pc), .link(link), .taken(taken)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] m, input bit st, input bit r);
        if (r) return "R1";
        if (st) return "R8";
        case (m)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R2";
        endcase
    endfunction

    // Behavioural model of one cycle: expected taken, then the state after the edge.
    task automatic step(input bit r, input bit st, input logic [2:0] m,
                        input logic [1:0] cs, input logic [31:0] im,
                        input logic [31:0] a, input logic [31:0] b,
                        input bit f, input bit lr);
        bit          cond;
        bit          exp_tk;
        int          off;
        logic [31:0] nxt;
        string       t;
        @(negedge clk);
        rst = r; stall = st; mode = m; cond_sel = cs; imm = im;
        rs_a = a; rs_b = b; flag = f; link_req = lr;
        case (cs)
            2'd0: cond = 1;
            2'd1: cond = (a == b);
            2'd2: cond = (a != 0);
            default: cond = f;
        endcase
        if (m >= 3'd1 && m <= 3'd3) exp_tk = cond;
        else if (m == 3'd4) exp_tk = (a == b);
        else exp_tk = 0;
        #1;
        chk((m >= 3'd1 && m <= 3'd3 && cs != 0) ? "R7" : "R10", "taken",
            {31'd0, taken}, {31'd0, exp_tk});
        off = int'(im[9:0]);
        if (off >= 512) off -= 1024;
        nxt = m_pc + 4;
        if (exp_tk) begin
            case (m)
                3'd1: nxt = im;
                3'd2: nxt = m_pc + 4 + 32'(off * 4);
                3'd3: nxt = a;
                default: nxt = m_pc + 8;
            endcase
        end
        if (r) begin
            m_pc = RV; m_link = '0;
        end else if (!st) begin
            if (lr) m_link = m_pc + 4;
            m_pc = nxt;
        end
        @(posedge clk);
        #1;
        t = (!exp_tk && !r && !st && m >= 3'd1 && m <= 3'd3) ? "R7" : tag_of(m, st, r);
        chk(t, "pc", pc, m_pc);
        chk((lr && !st && !r) ? "R9" : (st && !r ? "R8" : "R9"), "link", link, m_link);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 1, 0, 32'hDEAD_0000, 0, 0, 0, 1);         // R1 reset beats stall
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);                     // R2
        for (int c = 5; c < 8; c++)
            step(0, 0, 3'(c), 2'd0, 32'h0000_9000, 5, 5, 1, 0); // R2 unused codes
        step(0, 0, 1, 0, 32'h0000_4000, 0, 0, 0, 1);         // R3 + R9
        step(0, 0, 2, 0, 32'h0000_0003, 0, 0, 0, 0);         // R4 forward
        step(0, 0, 2, 0, 32'h0000_03FE, 0, 0, 0, 0);         // R4 backward
        step(0, 0, 2, 0, 32'hFFFF_F200, 0, 0, 0, 0);         // R4 most negative
        step(0, 0, 3, 0, 0, 32'h0000_8000, 0, 0, 0);         // R5
        step(0, 0, 4, 3, 0, 7, 7, 0, 0);                     // R6 equal
        step(0, 0, 4, 0, 0, 7, 8, 1, 0);                     // R6 unequal
        step(0, 0, 1, 1, 32'h100, 3, 4, 0, 0);               // R7 eq false
        step(0, 0, 1, 1, 32'h200, 4, 4, 0, 0);               // R7 eq true
        step(0, 0, 3, 2, 0, 0, 0, 1, 0);                     // R7 nz false
        step(0, 0, 3, 2, 0, 32'h300, 0, 0, 0);               // R7 nz true
        step(0, 0, 2, 3, 32'h10, 0, 0, 0, 0);                // R7 flag false
        step(0, 0, 2, 3, 32'h10, 0, 0, 1, 0);                // R7 flag true
        step(0, 1, 1, 0, 32'h7777, 0, 0, 0, 1);              // R8 stall
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);                     // R9
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a = (($urandom % 4) == 0) ? 0 : $urandom;
            logic [31:0] b = (($urandom % 2) == 0) ? a : $urandom;
            step(i == 300, ($urandom % 8) == 0, 3'($urandom), 2'($urandom),
                 $urandom, a, b, 1'($urandom), 1'($urandom));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule